// File: doc/BRIEF.md
# Serial Audio Receiver with Slot-Length Autodetect

This block sits in the bit-clock domain, at the edge of an audio datapath. It takes the three wires of an I2S-style link: bit clock, word select and serial data. It turns them into a pair of parallel channel samples and raises a one-cycle strobe when both are ready. No configuration tells it how wide the slots are. It measures every channel slot against the word-select edges and decides for itself whether the link carries 16-bit slots (32 clocks per stereo frame) or 32-bit slots (64 clocks per stereo frame).

Two static inputs adapt the block to the transmitter. One inverts which word-select level marks the left channel. The other chooses whether the first data bit of a slot shares its clock with the word-select change or follows one clock later. Every sample leaves the block as a 32-bit left-justified value. A short-slot sample has its lower half cleared. The block reports the mode in force, pulses an output when that mode changes so that downstream logic can mute, and pulses an error output when it sees a slot that is badly sized or unmatched.

Top module: `i2s_autolen_rx`

## Requirements
- R1: Serial data is sampled on the rising bit-clock edge, MSB first. With `msb_delay` low, the MSB of a slot is the bit present in the cycle in which word select takes its new level.
- R2: With `msb_delay` high, the MSB of a slot is the bit present one bit-clock cycle after the word-select change. The LSB of the previous slot then shares its cycle with that change.
- R3: With `ws_invert` low, the left slot is the one with word select low. With `ws_invert` high, the left slot is the one with word select high.
- R4: A slot of 16 clocks is a short slot. When a frame of two short slots completes, `long_mode` is 0 and each output carries the 16 received bits in bits [31:16], with bits [15:0] zero.
- R5: A slot of 32 clocks is a long slot. When a frame of two long slots completes, `long_mode` is 1 and each output carries all 32 received bits.
- R6: `smp_valid` is high for exactly one cycle. With `msb_delay` low, that cycle is the one after the rising edge on which the word-select change that ends the right slot is sampled. `left_out` and `right_out` change only in a strobe cycle and otherwise hold their values.
- R7: A slot whose length is neither 16 nor 32 clocks, or a right slot whose length differs from the left slot before it, raises `frame_err` for one cycle. No strobe is given and the outputs keep their previous sample.
- R8: Once a mode is established, a single well-formed frame of the other slot length is dropped and leaves `long_mode` unchanged. If the next frame has that same other length, the mode switches: its sample is strobed, `long_mode` updates and `mode_change` pulses in the strobe cycle.
- R9: After reset, all outputs are zero and no strobe is given until the first complete, correctly sized frame. That frame sets the mode without pulsing `mode_change`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ws_in | input | 1 | Word select from the link |
| sd_in | input | 1 | Serial data from the link |
| ws_invert | input | 1 | Left channel on word select high when set |
| msb_delay | input | 1 | MSB one clock after the word-select change when set |
| left_out | output | 32 | Left sample, left-justified |
| right_out | output | 32 | Right sample, left-justified |
| smp_valid | output | 1 | One-cycle strobe for a new sample pair |
| long_mode | output | 1 | 1 when 32-bit slots are in force |
| mode_change | output | 1 | Pulses when the mode switches |
| frame_err | output | 1 | Pulses on a badly sized or unmatched slot |

## Verification
A mode switch and a sample strobe land in the same cycle: the second consecutive frame of the new length both delivers its sample and flips the mode. The bench provokes this by sending one short frame, then two long frames. It checks that the first long frame leaves the strobe count and the mode untouched. It then checks that the second long frame gives exactly one strobe and one mode-change pulse, with `long_mode` set and the second frame's words on the outputs. A checker property also requires every mode-change pulse to coincide with a strobe and with a changed mode.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = $clog2(WORD_W) + 2;

    typedef struct packed {
        logic              done;
        logic              left;
        logic [CNT_W-1:0]  len;
        logic [WORD_W-1:0] word;
    } slot_t;
endpackage

// File: rtl/i2s_rx_align.sv
module i2s_rx_align (
    input  logic clk,
    input  logic rst_n,
    input  logic ws_in,
    input  logic msb_delay,
    output logic ws_edge,
    output logic ws_prev
);
    typedef struct packed {
        logic raw;
        logic eff;
    } align_t;

    align_t st_d, st_q;
    logic   eff_now;

    // Delayed mode: use last cycle's word select so the slot boundary moves one clock later
    always_comb begin
        eff_now  = msb_delay ? st_q.raw : ws_in;
        st_d.raw = ws_in;
        st_d.eff = eff_now;
        ws_edge  = eff_now ^ st_q.eff;
        ws_prev  = st_q.eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/i2s_rx_slot.sv
module i2s_rx_slot
    import i2s_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sd_in,
    input  logic  ws_edge,
    input  logic  ws_prev,
    input  logic  ws_invert,
    output slot_t slot_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A count of zero means no boundary has been seen since reset
        slot_o.done = ws_edge && (st_q.cnt != '0);
        slot_o.left = (ws_prev == ws_invert);
        slot_o.len  = st_q.cnt;
        slot_o.word = st_q.sh;

        st_d.sh = {st_q.sh[WORD_W-2:0], sd_in};
        if (ws_edge)
            st_d.cnt = CNT_W'(1);
        else if ((st_q.cnt != '0) && (st_q.cnt != '1))
            st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/i2s_rx_frame.sv
module i2s_rx_frame
    import i2s_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slot_t             slot_i,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              smp_valid,
    output logic              long_mode,
    output logic              mode_change,
    output logic              frame_err
);
    typedef struct packed {
        logic [WORD_W-1:0] lw;
        logic              lok;
        logic              llong;
        logic [WORD_W-1:0] lout;
        logic [WORD_W-1:0] rout;
        logic              vld;
        logic              err;
        logic              chg;
        logic              lng;
        logic              known;
        logic              cand;
    } frame_st_t;

    frame_st_t         st_d, st_q;
    logic              is_short, is_long, len_ok;
    logic [WORD_W-1:0] just;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        st_d.chg = 1'b0;

        is_short = (slot_i.len == CNT_W'(HALF_W));
        is_long  = (slot_i.len == CNT_W'(WORD_W));
        len_ok   = is_short || is_long;
        just     = is_short ? {slot_i.word[HALF_W-1:0], {HALF_W{1'b0}}} : slot_i.word;

        if (slot_i.done) begin
            if (slot_i.left) begin
                st_d.lw    = just;
                st_d.lok   = len_ok;
                st_d.llong = is_long;
                if (!len_ok) begin
                    st_d.err  = 1'b1;
                    st_d.cand = 1'b0;
                end
            end else begin
                st_d.lok = 1'b0;
                if (!len_ok) begin
                    st_d.err  = 1'b1;
                    st_d.cand = 1'b0;
                end else if (st_q.lok) begin
                    if (is_long != st_q.llong) begin
                        st_d.err  = 1'b1;
                        st_d.cand = 1'b0;
                    end else if (!st_q.known || (is_long == st_q.lng)) begin
                        st_d.lout  = st_q.lw;
                        st_d.rout  = just;
                        st_d.vld   = 1'b1;
                        st_d.lng   = is_long;
                        st_d.known = 1'b1;
                        st_d.cand  = 1'b0;
                    end else if (st_q.cand) begin
                        st_d.lout = st_q.lw;
                        st_d.rout = just;
                        st_d.vld  = 1'b1;
                        st_d.lng  = is_long;
                        st_d.chg  = 1'b1;
                        st_d.cand = 1'b0;
                    end else begin
                        st_d.cand = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_out    = st_q.lout;
    assign right_out   = st_q.rout;
    assign smp_valid   = st_q.vld;
    assign long_mode   = st_q.lng;
    assign mode_change = st_q.chg;
    assign frame_err   = st_q.err;
endmodule

// File: rtl/i2s_autolen_rx.sv
module i2s_autolen_rx
    import i2s_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ws_in,
    input  logic        sd_in,
    input  logic        ws_invert,
    input  logic        msb_delay,
    output logic [31:0] left_out,
    output logic [31:0] right_out,
    output logic        smp_valid,
    output logic        long_mode,
    output logic        mode_change,
    output logic        frame_err
);
    logic  ws_edge, ws_prev;
    slot_t slot;

    i2s_rx_align u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .ws_in     (ws_in),
        .msb_delay (msb_delay),
        .ws_edge   (ws_edge),
        .ws_prev   (ws_prev)
    );

    i2s_rx_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_in     (sd_in),
        .ws_edge   (ws_edge),
        .ws_prev   (ws_prev),
        .ws_invert (ws_invert),
        .slot_o    (slot)
    );

    i2s_rx_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_i      (slot),
        .left_out    (left_out),
        .right_out   (right_out),
        .smp_valid   (smp_valid),
        .long_mode   (long_mode),
        .mode_change (mode_change),
        .frame_err   (frame_err)
    );
endmodule

// File: rtl/i2s_rx_chk.sv
module i2s_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] left_out,
    input logic [31:0] right_out,
    input logic        smp_valid,
    input logic        long_mode,
    input logic        mode_change,
    input logic        frame_err
);
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> ($stable(left_out) && $stable(right_out)));

    assert_short_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !long_mode) |-> ((left_out[15:0] == 16'h0) && (right_out[15:0] == 16'h0)));

    assert_switch_with_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |-> (smp_valid && (long_mode != $past(long_mode))));

    assert_error_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !smp_valid);
endmodule

bind i2s_autolen_rx i2s_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .left_out    (left_out),
    .right_out   (right_out),
    .smp_valid   (smp_valid),
    .long_mode   (long_mode),
    .mode_change (mode_change),
    .frame_err   (frame_err)
);

// File: tb/sim_i2s_autolen_rx.sv
`timescale 1ns/1ps
module sim_i2s_autolen_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws_in = 1'b0, sd_in = 1'b0, ws_invert = 1'b0, msb_delay = 1'b0;
    logic [31:0] left_out, right_out;
    logic        smp_valid, long_mode, mode_change, frame_err;

    int n_checks = 0, n_errs = 0;
    int n_strobe = 0, n_ferr = 0, n_chg = 0;
    logic carry = 1'b0;

    always #10 clk = ~clk;

    i2s_autolen_rx u0 (
        .clk(clk), .rst_n(rst_n), .ws_in(ws_in), .sd_in(sd_in),
        .ws_invert(ws_invert), .msb_delay(msb_delay),
        .left_out(left_out), .right_out(right_out), .smp_valid(smp_valid),
        .long_mode(long_mode), .mode_change(mode_change), .frame_err(frame_err)
    );

    always @(negedge clk) if (rst_n) begin
        if (smp_valid)   n_strobe++;
        if (frame_err)   n_ferr++;
        if (mode_change) n_chg++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_slot(input logic lvl, input logic [31:0] data, input int len);
        for (int i = 0; i < len; i++) begin
            ws_in = lvl;
            if (msb_delay) sd_in = (i == 0) ? carry : data[len - i];
            else           sd_in = data[len - 1 - i];
            @(negedge clk);
        end
        carry = data[0];
    endtask

    task automatic restart(input logic inv, input logic dly);
        rst_n = 1'b0;
        ws_invert = inv; msb_delay = dly;
        ws_in = 1'b0; sd_in = 1'b0; carry = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive_slot(!inv, 32'h0, 16);
    endtask

    task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input int len);
        drive_slot(ws_invert, l, len);
        drive_slot(!ws_invert, r, len);
    endtask

    task automatic trailer();
        drive_slot(ws_invert, 32'h0, 3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(left_out == 0 && right_out == 0 && !smp_valid && !long_mode && !mode_change && !frame_err,
            "R9 reset state", {left_out, right_out}, 64'h0);
    endtask

    task automatic t_short_timing();
        restart(1'b0, 1'b0);
        send_frame(32'hA5C3, 32'h1234, 16);
        ws_in = 1'b0; sd_in = 1'b0;
        @(negedge clk);
        chk(smp_valid == 1'b1, "R6 strobe cycle", smp_valid, 1);
        chk(left_out == 32'hA5C3_0000, "R1 R4 left short", left_out, 32'hA5C3_0000);
        chk(right_out == 32'h1234_0000, "R4 right short", right_out, 32'h1234_0000);
        chk(long_mode == 1'b0 && mode_change == 1'b0, "R9 first frame no change", {long_mode, mode_change}, 0);
        @(negedge clk);
        chk(smp_valid == 1'b0, "R6 strobe one cycle", smp_valid, 0);
        drive_slot(1'b0, 32'h7777, 15);
        drive_slot(1'b1, 32'h8888, 8);
        chk(left_out == 32'hA5C3_0000 && right_out == 32'h1234_0000, "R6 hold", left_out, 32'hA5C3_0000);
    endtask

    task automatic t_long();
        int s0;
        restart(1'b0, 1'b0);
        s0 = n_strobe;
        send_frame(32'hDEADBEEF, 32'h0BADF00D, 32);
        trailer();
        chk(n_strobe - s0 == 1, "R5 one strobe", n_strobe - s0, 1);
        chk(left_out == 32'hDEADBEEF && right_out == 32'h0BADF00D, "R5 long words", left_out, 32'hDEADBEEF);
        chk(long_mode == 1'b1, "R5 long mode", long_mode, 1);
    endtask

    task automatic t_delay();
        restart(1'b0, 1'b1);
        send_frame(32'h8001, 32'hC3A5, 16);
        trailer();
        chk(left_out == 32'h8001_0000, "R2 delayed left", left_out, 32'h8001_0000);
        chk(right_out == 32'hC3A5_0000, "R2 delayed right", right_out, 32'hC3A5_0000);
    endtask

    task automatic t_invert();
        restart(1'b1, 1'b0);
        send_frame(32'h1111, 32'hEEEE, 16);
        trailer();
        chk(left_out == 32'h1111_0000 && right_out == 32'hEEEE_0000, "R3 inverted polarity",
            {left_out, right_out}, {32'h1111_0000, 32'hEEEE_0000});
    endtask

    task automatic t_errors();
        int s0, e0;
        restart(1'b0, 1'b0);
        send_frame(32'h4242, 32'h2424, 16);
        s0 = n_strobe; e0 = n_ferr;
        drive_slot(1'b0, 32'hFFFFF, 20);
        drive_slot(1'b1, 32'h5555, 16);
        chk(n_ferr - e0 == 1, "R7 bad length flagged", n_ferr - e0, 1);
        send_frame(32'h9999, 32'h12345678, 0);
        drive_slot(1'b0, 32'h9999, 16);
        drive_slot(1'b1, 32'h12345678, 32);
        trailer();
        chk(n_ferr - e0 == 2, "R7 mismatch flagged", n_ferr - e0, 2);
        chk(n_strobe == s0 + 1, "R7 no strobe on error", n_strobe - s0, 1);
        chk(left_out == 32'h4242_0000 && right_out == 32'h2424_0000, "R7 outputs kept", left_out, 32'h4242_0000);
    endtask

    task automatic t_switch();
        int s0, c0;
        restart(1'b0, 1'b0);
        s0 = n_strobe; c0 = n_chg;
        send_frame(32'h0F0F, 32'hF0F0, 16);
        send_frame(32'hAAAA5555, 32'h5555AAAA, 32);
        drive_slot(1'b0, 32'hCAFEF00D, 32);
        chk(n_strobe - s0 == 1 && long_mode == 1'b0 && n_chg == c0, "R8 single foreign frame dropped",
            {n_strobe - s0, long_mode}, 1);
        drive_slot(1'b1, 32'h600DD00D, 32);
        trailer();
        chk(n_strobe - s0 == 2 && n_chg - c0 == 1, "R8 switch strobe and pulse", n_chg - c0, 1);
        chk(long_mode == 1'b1 && left_out == 32'hCAFEF00D && right_out == 32'h600DD00D, "R8 new mode words",
            left_out, 32'hCAFEF00D);
    endtask

    task automatic t_bad_first();
        int s0;
        restart(1'b0, 1'b0);
        s0 = n_strobe;
        send_frame(32'h1, 32'h2, 20);
        trailer();
        chk(n_strobe == s0 && left_out == 0 && right_out == 0, "R9 no output before good frame",
            n_strobe - s0, 0);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_errs++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_short_timing();
        t_long();
        t_delay();
        t_invert();
        t_errors();
        t_switch();
        t_bad_first();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule